// File: doc/BRIEF.md
# Serial word EEPROM slave

This block is the serial front end and storage of a small word-organised EEPROM, seen from a bus master that drives a chip select, a serial clock and a data line. Every operation opens with a start bit of 1. Two operation bits and a six-bit word address follow. A read returns the addressed 16-bit word on the output pin, and a write shifts in a 16-bit word and then runs a timed internal cycle. During that cycle the master can poll busy/ready status on the same output pin.

The serial clock is sampled by the block's own clock `clk`. A serial-clock rising edge is acted on at the first `clk` edge that sees `sck` high after it was low. The tri-state output pin is modelled as a value `dout` and an enable `dout_en`. The 64-word array is held in registers and clears to zero at reset.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset `dout_en` is 0. The array holds all zeros, and no write cycle is running.
- R2: While idle, 0 bits sampled on serial-clock rising edges are skipped. The first 1 bit is the start bit. The next two bits are the operation code, first bit first: 1,0 selects read, 0,1 selects write. Six address bits follow, most significant first.
- R3: On a read, the rising edge that captures the last address bit enables `dout` with a dummy 0. Each of the next 16 rising edges presents the next bit of the stored word, most significant bit first.
- R4: While chip select stays high and no serial-clock rising edge occurs, `dout` and `dout_en` keep their values.
- R5: The rising edge after the last data bit of a read sets `dout_en` to 0.
- R6: With chip select low, `dout_en` is 0 in the same cycle. A partial read or write is dropped, and the memory keeps its contents.
- R7: On a write, the 16 data bits that follow the address are taken most significant first. After the write cycle ends, the addressed word reads back as that value.
- R8: The write cycle starts at the rising edge that captures the last data bit and lasts `WR_CYCLES` clock cycles. Once chip select is low and then high again, `dout_en` is 1 and `dout` is 0 while the cycle runs and 1 once it has ended.
- R9: Serial input received while a write cycle runs has no effect. A second write attempted during the cycle does not change its target word.
- R10: While status is shown, dropping chip select sets `dout_en` to 0. A write cycle that is running still completes after chip select falls.
- R11: The operation codes 0,0 and 1,1 produce no output and do not change memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also times the write cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock, sampled by `clk` |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out value |
| dout_en | output | 1 | Output enable for `dout` (0 = high impedance) |

## Verification
The assertions assume that `cs`, `sck` and `din` are synchronous to `clk`. They also assume that each `sck` level lasts at least one `clk` cycle, so that every serial edge is seen exactly once. The bench changes these inputs only on falling `clk` edges and holds every serial-clock phase for a full cycle. It keeps the write-cycle length short through the parameter, so that random reads and writes to random addresses, with random data, fit in the run.

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 6,
  parameter int WR_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sck,
  input  logic din,
  output logic dout,
  output logic dout_en
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CMD_W = ADDR_W + 2;
  localparam int MAXB  = (DATA_W > CMD_W) ? DATA_W : CMD_W;
  localparam int CNT_W = $clog2(MAXB + 1);
  localparam int TMR_W = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_RD, S_WR, S_DONE} st_t;

  st_t                state;
  logic               sck_q, busy, stat_pend, rd_en, rd_bit;
  logic [CNT_W-1:0]   cnt;
  logic [CMD_W-2:0]   cmd_sr;
  logic [DATA_W-1:0]  sh;
  logic [ADDR_W-1:0]  addr_q;
  logic [TMR_W-1:0]   tmr;
  logic [DATA_W-1:0]  mem [DEPTH];

  wire              sck_rise = sck & ~sck_q;
  wire [CMD_W-1:0]  cmd_full = {cmd_sr, din};
  wire [1:0]        op       = cmd_full[CMD_W-1:CMD_W-2];
  wire              show_st  = stat_pend & (state == S_IDLE);

  assign dout_en = cs & (rd_en | show_st);
  assign dout    = rd_en ? rd_bit : ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sck_q     <= 1'b0;
      busy      <= 1'b0;
      stat_pend <= 1'b0;
      rd_en     <= 1'b0;
      rd_bit    <= 1'b0;
      cnt       <= '0;
      cmd_sr    <= '0;
      sh        <= '0;
      addr_q    <= '0;
      tmr       <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      sck_q <= sck;
      if (busy) begin
        if (tmr == '0) begin
          busy         <= 1'b0;
          mem[addr_q]  <= sh;
        end else begin
          tmr <= tmr - 1'b1;
        end
      end
      if (!cs) begin
        state <= S_IDLE;
        rd_en <= 1'b0;
        cnt   <= '0;
      end else if (sck_rise) begin
        unique case (state)
          S_IDLE: if (din && !busy) begin
            state     <= S_CMD;
            stat_pend <= 1'b0;
            cnt       <= '0;
          end
          S_CMD: begin
            cmd_sr <= cmd_full[CMD_W-2:0];
            cnt    <= cnt + 1'b1;
            if (cnt == CNT_W'(CMD_W - 1)) begin
              cnt    <= '0;
              addr_q <= cmd_full[ADDR_W-1:0];
              if (op == 2'b10) begin
                state  <= S_RD;
                sh     <= mem[cmd_full[ADDR_W-1:0]];
                rd_en  <= 1'b1;
                rd_bit <= 1'b0;
              end else if (op == 2'b01) begin
                state <= S_WR;
              end else begin
                state <= S_DONE;
              end
            end
          end
          S_RD: begin
            if (cnt == CNT_W'(DATA_W)) begin
              rd_en <= 1'b0;
              state <= S_DONE;
            end else begin
              rd_bit <= sh[DATA_W-1];
              sh     <= sh << 1;
              cnt    <= cnt + 1'b1;
            end
          end
          S_WR: begin
            sh  <= {sh[DATA_W-2:0], din};
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(DATA_W - 1)) begin
              state       <= S_DONE;
              busy        <= 1'b1;
              stat_pend   <= 1'b1;
              tmr         <= TMR_W'(WR_CYCLES - 1);
              mem[addr_q] <= '1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6
  cs_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (state == S_IDLE) && !rd_en);

  // R3
  rd_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && sck_rise && state == S_CMD && cnt == CNT_W'(CMD_W - 1) && op == 2'b10)
    |=> (!cs || (dout_en && !dout)));

  // R5
  rd_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && sck_rise && state == S_RD && cnt == CNT_W'(DATA_W)) |=> !dout_en);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state == S_IDLE) |=> (state == S_IDLE));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(state) == S_WR));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && $past(cs) && !$past(sck_rise) && $past(state) == S_RD && state == S_RD)
    |-> ($stable(dout) && $stable(dout_en)));
endmodule

// File: tb/test_serial_eeprom_slave.sv
module test_serial_eeprom_slave;
  localparam int WRC = 300;
  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sck = 1'b0, din = 1'b0;
  logic dout, dout_en;
  int errs = 0, checks = 0;
  logic [15:0] model [64];

  serial_eeprom_slave #(.DATA_W(16), .ADDR_W(6), .WR_CYCLES(WRC)) i_serial_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .din(din),
    .dout(dout), .dout_en(dout_en));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic bitof(input logic [15:0] w, input int i);
    return w[15 - i];
  endfunction

  task automatic pulse(input logic d);
    din = d; sck = 1'b0;
    @(negedge clk); sck = 1'b1;
    @(negedge clk);
  endtask

  task automatic header(input logic [1:0] op, input logic [5:0] a);
    pulse(1'b1);
    pulse(op[1]); pulse(op[0]);
    for (int i = 5; i >= 0; i--) pulse(a[i]);
  endtask

  task automatic drop_cs();
    sck = 1'b0; cs = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic do_read(input logic [5:0] a, input string tag);
    logic [15:0] got;
    cs = 1'b1; @(negedge clk);
    header(2'b10, a);
    chk(dout_en && !dout, {tag, " R3 dummy"}, {dout_en, dout}, 2);
    for (int i = 0; i < 16; i++) begin
      pulse(1'b0);
      got[15 - i] = dout;
    end
    chk(got == model[a], {tag, " R3 word"}, got, model[a]);
    repeat (4) @(negedge clk);
    chk(dout_en && dout == bitof(model[a], 15), "R4 hold", dout, bitof(model[a], 15));
    pulse(1'b0);
    chk(!dout_en, "R5 hiz after D0", dout_en, 0);
    drop_cs();
  endtask

  task automatic send_write(input logic [5:0] a, input logic [15:0] d);
    cs = 1'b1; @(negedge clk);
    header(2'b01, a);
    for (int i = 0; i < 16; i++) pulse(d[15 - i]);
  endtask

  task automatic wait_ready(input bit exact);
    int n = 0;
    cs = 1'b0; sck = 1'b0;
    forever begin
      @(negedge clk); n++;
      if (n >= 2 && dout_en && dout) break;
      if (n == 2) chk(dout_en && !dout, "R8 busy status", {dout_en, dout}, 2);
      if (n == 1) cs = 1'b1;
      if (n > WRC + 20) break;
    end
    if (exact) chk(n == WRC, "R8 cycle length", n, WRC);
    else chk(n <= WRC, "R8 ready", n, WRC);
    cs = 1'b0; #1;
    chk(!dout_en, "R10 status hiz", dout_en, 0);
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd41));
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dout_en, "R1 reset dout_en", dout_en, 0);
    do_read(6'd5, "R1 zero");

    // R7 R8 exact timing
    send_write(6'h2A, 16'hA5C3); model[6'h2A] = 16'hA5C3;
    wait_ready(1'b1);
    do_read(6'h2A, "R7");

    // R2 leading zeros
    cs = 1'b1; @(negedge clk);
    pulse(1'b0); pulse(1'b0);
    header(2'b10, 6'h2A);
    chk(dout_en && !dout, "R2 leading zeros", {dout_en, dout}, 2);
    pulse(1'b0);
    chk(dout == 1'b1, "R2 first bit", dout, 1);
    drop_cs();

    // R6 abort read mid-word
    cs = 1'b1; @(negedge clk);
    header(2'b10, 6'h2A);
    pulse(1'b0); pulse(1'b0);
    cs = 1'b0; #1;
    chk(!dout_en, "R6 cs drop hiz", dout_en, 0);
    drop_cs();

    // R6 abort partial write
    cs = 1'b1; @(negedge clk);
    header(2'b01, 6'h2A);
    for (int i = 0; i < 8; i++) pulse(1'b1);
    drop_cs();
    do_read(6'h2A, "R6 partial write");

    // R9 write attempt during busy; R10 completes after cs drop
    send_write(6'h11, 16'h1234); model[6'h11] = 16'h1234;
    drop_cs();
    send_write(6'h12, 16'hFFFF);
    drop_cs();
    wait_ready(1'b0);
    do_read(6'h12, "R9 ignored");
    do_read(6'h11, "R10 completes");

    // R11 unsupported codes
    for (int k = 0; k < 2; k++) begin
      cs = 1'b1; @(negedge clk);
      header(k == 0 ? 2'b00 : 2'b11, 6'h11);
      for (int i = 0; i < 17; i++) pulse(1'b1);
      chk(!dout_en, "R11 no output", dout_en, 0);
      drop_cs();
    end
    do_read(6'h11, "R11 unchanged");

    // random mix
    for (int it = 0; it < 12; it++) begin
      logic [5:0] a = 6'($urandom % 64);
      logic [15:0] d = 16'($urandom);
      if ($urandom % 2 == 0) begin
        send_write(a, d); model[a] = d;
        wait_ready(1'b0);
      end
      do_read(a, "R7 random");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule